// File: doc/BRIEF.md
# Strip Frame Baseline Correction and Hit Filter

This block cleans up the digitized output of a strip-detector readout chip before the data are shipped off. A trigger delivers three or six consecutive samples, each a frame of 128 channel codes of 10 bits. The block removes a stored per-channel pedestal from every code. It then runs two common-mode stages, each of which estimates the shared baseline shift of a group of neighbouring channels and takes it away. Finally it keeps only the channels whose corrected signal rises above a per-channel threshold. Each kept channel leaves as one output word that carries the channel number and every sample of the trigger.

The whole trigger is first captured into an internal buffer. The two correction passes and the hit search then walk that buffer one value per clock, so the input is closed (`in_ready` low) from the last input beat until the last hit word has been taken. Pedestals and thresholds are written through a simple write port between triggers. A bypass setting turns the block into a transparent recorder for calibration: every channel is sent with its raw codes.

Top module: `strip_zs`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: A trigger starts only with an accepted beat that has `in_first` = 1, and beats without it while idle are ignored. Once the last beat of the trigger is taken, `in_ready` is 0 on the next cycle and stays 0 until all output words have been accepted.
- R3: `in_six` on the first beat selects 6 samples (1) or 3 samples (0) for that trigger. `out_six` reports the choice, and with 3 samples the output slots 3 to 5 are zero.
- R4: Outside bypass, each value is first turned into the signed 12-bit difference raw code minus the pedestal stored for its channel.
- R5: Stage one, for each sample and each channel group, sums the pedestal-corrected values, shifts the sum arithmetically right by log2 of the group size (rounding toward minus infinity), and subtracts that average from each member. Results are saturated to the range -2048 to 2047.
- R6: `cfg_grp` on the first beat selects the group size: 0 gives 16 channels, 1 gives 32, and 2 or 3 gives 128. Groups are aligned runs of consecutive channel numbers.
- R7: Stage two repeats stage one on the stage-one results, except that a channel whose stage-one value is greater than its threshold adds 0 to the group sum. The shift still uses the full group size.
- R8: Outside bypass, a channel is sent only if at least one of its stage-two samples is greater (signed) than its 12-bit signed threshold. Words leave in ascending channel order.
- R9: An output word carries the channel number on `out_chan`, and sample k in `out_samples[12k+11:12k]` as a 12-bit two's complement value.
- R10: With `cfg_bypass` = 1 on the first beat, all 128 channels are sent in order, each slot holding the raw 10-bit code zero-extended, with no pedestal, common-mode or threshold applied.
- R11: While `out_valid` is 1 and `out_ready` is 0, the output word and channel stay unchanged.
- R12: A write with `cfg_we` = 1 stores `cfg_wdata[9:0]` as the pedestal of channel `cfg_addr` when `cfg_sel` = 0, and `cfg_wdata` as its threshold when `cfg_sel` = 1. The new value applies to the next trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bypass | input | 1 | Raw pass-through mode, sampled on the first beat |
| cfg_grp | input | 2 | Common-mode group size select, sampled on the first beat |
| cfg_we | input | 1 | Table write enable |
| cfg_sel | input | 1 | Table select: 0 pedestal, 1 threshold |
| cfg_addr | input | 7 | Channel written |
| cfg_wdata | input | 12 | Write data |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat |
| in_first | input | 1 | Marks channel 0 of the first sample of a trigger |
| in_six | input | 1 | Six-sample trigger when set, read on the first beat |
| in_chan | input | 7 | Channel number of the beat |
| in_data | input | 10 | ADC code |
| out_valid | output | 1 | Hit word present |
| out_ready | input | 1 | Consumer takes the word |
| out_chan | output | 7 | Channel of the word |
| out_six | output | 1 | Trigger had six samples |
| out_samples | output | 72 | Six 12-bit sample slots |

## Verification
The assertions rely on the input following the frame order: within a trigger, channels arrive as 0 to 127 without gaps for each sample in turn, and `in_first` is raised only on the first of them. They also assume that table writes and the configuration inputs change only while no trigger is being taken in or processed. The bench builds every trigger as a complete, in-order beat sequence driven one per cycle. It rewrites the tables only after the previous trigger has fully drained, and the only stray beats it sends carry `in_first` = 0 and arrive while the block is idle.

// File: rtl/strip_zs.sv
module strip_zs #(
  parameter int NCH  = 128,
  parameter int ADCW = 10,
  parameter int VALW = 12,
  parameter int MAXS = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_bypass,
  input  logic [1:0]             cfg_grp,
  input  logic                   cfg_we,
  input  logic                   cfg_sel,
  input  logic [$clog2(NCH)-1:0] cfg_addr,
  input  logic [VALW-1:0]        cfg_wdata,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic                   in_first,
  input  logic                   in_six,
  input  logic [$clog2(NCH)-1:0] in_chan,
  input  logic [ADCW-1:0]        in_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [$clog2(NCH)-1:0] out_chan,
  output logic                   out_six,
  output logic [MAXS*VALW-1:0]   out_samples
);
  localparam int CHW  = $clog2(NCH);
  localparam int SW   = $clog2(MAXS);
  localparam int SUMW = VALW + CHW + 1;
  localparam int DEP  = (2**SW) * NCH;

  typedef enum logic [2:0] {LOAD, SUM, SUB, GATH, SEND} st_t;
  st_t st;

  logic [ADCW-1:0]        ped_m [NCH];
  logic signed [VALW-1:0] thr_m [NCH];
  logic signed [VALW-1:0] buf_m [DEP];

  logic                   started, pass2, six_q, byp_q, hit;
  logic [1:0]             grp_q;
  logic [SW-1:0]          samp;
  logic [CHW-1:0]         ch;
  logic signed [SUMW-1:0] acc;
  logic signed [VALW-1:0] avg;
  logic [MAXS*VALW-1:0]   word;
  int                     sh;
  logic [CHW-1:0]         gmask;

  assign in_ready    = (st == LOAD);
  assign out_valid   = (st == SEND);
  assign out_chan    = ch;
  assign out_six     = six_q;
  assign out_samples = word;

  wire take      = in_valid && in_ready && (in_first || started);
  wire [SW-1:0] ls = in_first ? '0 : samp;
  wire six_now   = in_first ? in_six : six_q;
  wire byp_now   = in_first ? cfg_bypass : byp_q;
  wire last_beat = take && (in_chan == '1) && (ls == (six_now ? SW'(5) : SW'(2)));
  wire [SW-1:0] nlast = six_q ? SW'(5) : SW'(2);

  wire signed [VALW-1:0] dval = byp_now ? VALW'(in_data)
                                        : VALW'(in_data) - VALW'(ped_m[in_chan]);

  always_comb begin
    case (grp_q)
      2'd0:    sh = 4;
      2'd1:    sh = 5;
      default: sh = CHW;
    endcase
    gmask = CHW'((1 << sh) - 1);
  end

  wire signed [VALW-1:0] cur  = buf_m[{samp, ch}];
  wire signed [VALW-1:0] cth  = thr_m[ch];
  wire                   over = cur > cth;
  wire signed [VALW-1:0] term = (pass2 && over) ? '0 : cur;
  wire signed [SUMW-1:0] acc_n = acc + SUMW'(term);
  wire signed [SUMW-1:0] shd   = acc_n >>> sh;
  wire signed [VALW-1:0] avg_n = shd[VALW-1:0];
  wire                   gend  = (ch & gmask) == gmask;
  wire [VALW:0]          diff  = {cur[VALW-1], cur} - {avg[VALW-1], avg};
  wire [VALW-1:0]        satv  = (diff[VALW] != diff[VALW-1])
                                 ? (diff[VALW] ? {1'b1, {(VALW-1){1'b0}}} : {1'b0, {(VALW-1){1'b1}}})
                                 : diff[VALW-1:0];
  wire                   hit_n = hit | over;

  always_ff @(posedge clk) begin
    if (cfg_we && !cfg_sel) ped_m[cfg_addr] <= cfg_wdata[ADCW-1:0];
    if (cfg_we &&  cfg_sel) thr_m[cfg_addr] <= cfg_wdata;
    if (take)            buf_m[{ls, in_chan}] <= dval;
    else if (st == SUB)  buf_m[{samp, ch}]    <= satv;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= LOAD; started <= 1'b0; pass2 <= 1'b0; six_q <= 1'b0; byp_q <= 1'b0;
      grp_q <= '0; samp <= '0; ch <= '0; acc <= '0; avg <= '0; word <= '0; hit <= 1'b0;
    end else begin
      case (st)
        LOAD: if (take) begin
          started <= 1'b1;
          if (in_first) begin six_q <= in_six; byp_q <= cfg_bypass; grp_q <= cfg_grp; end
          samp <= (in_chan == '1) ? ls + SW'(1) : ls;
          if (last_beat) begin
            started <= 1'b0; samp <= '0; ch <= '0; acc <= '0; pass2 <= 1'b0;
            word <= '0; hit <= 1'b0;
            st <= byp_now ? GATH : SUM;
          end
        end
        SUM: begin
          acc <= acc_n;
          if (gend) begin avg <= avg_n; st <= SUB; ch <= ch & ~gmask; end
          else ch <= ch + CHW'(1);
        end
        SUB: begin
          acc <= '0;
          ch  <= ch + CHW'(1);
          if (gend) begin
            st <= SUM;
            if (ch == '1) begin
              if (samp == nlast) begin
                samp <= '0;
                if (pass2) st <= GATH;
                pass2 <= 1'b1;
              end else samp <= samp + SW'(1);
            end
          end
        end
        GATH: begin
          word[int'(samp)*VALW +: VALW] <= cur;
          if (samp == nlast) begin
            samp <= '0;
            if (hit_n || byp_q) st <= SEND;
            else begin
              word <= '0; hit <= 1'b0;
              if (ch == '1) st <= LOAD; else ch <= ch + CHW'(1);
            end
          end else begin
            samp <= samp + SW'(1);
            hit  <= hit_n;
          end
        end
        SEND: if (out_ready) begin
          word <= '0; hit <= 1'b0;
          if (ch == '1) st <= LOAD;
          else begin ch <= ch + CHW'(1); st <= GATH; end
        end
        default: st <= LOAD;
      endcase
    end
  end

  logic [CHW-1:0] sent_ch;
  logic           sent_any;
  always_ff @(posedge clk) begin
    if (!rst_n) begin sent_any <= 1'b0; sent_ch <= '0; end
    else if (last_beat) sent_any <= 1'b0;
    else if (out_valid && out_ready) begin sent_any <= 1'b1; sent_ch <= out_chan; end
  end

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_chan) && $stable(out_samples));
  // R2
  close_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> !in_ready);
  // R3
  slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_six |-> out_samples[MAXS*VALW-1:3*VALW] == '0);
  // R10
  bypass_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && byp_q |-> out_samples[VALW-1:ADCW] == '0);
  // R8
  ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && sent_any |-> out_chan > sent_ch);
endmodule

// File: tb/strip_zs_test.sv
module strip_zs_test;
  logic clk = 0, rst_n = 0;
  logic cfg_bypass = 0, cfg_we = 0, cfg_sel = 0;
  logic [1:0] cfg_grp = 0;
  logic [6:0] cfg_addr = 0;
  logic [11:0] cfg_wdata = 0;
  logic in_valid = 0, in_first = 0, in_six = 0, out_ready = 0;
  logic [6:0] in_chan = 0;
  logic [9:0] in_data = 0;
  logic in_ready, out_valid, out_six;
  logic [6:0] out_chan;
  logic [71:0] out_samples;

  strip_zs uut (.clk, .rst_n, .cfg_bypass, .cfg_grp, .cfg_we, .cfg_sel, .cfg_addr,
    .cfg_wdata, .in_valid, .in_ready, .in_first, .in_six, .in_chan, .in_data,
    .out_valid, .out_ready, .out_chan, .out_six, .out_samples);

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  int ped[128], thr[128], raw[6][128], c1[6][128], c2[6][128];
  int exp_ch[128], exp_n;
  logic [71:0] exp_w[128];

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp); end
  endtask

  function automatic int sat(input int v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  task automatic model(input bit six, input bit byp, input int grp);
    int ns, g, shv, sum, a;
    logic [31:0] t;
    ns = six ? 6 : 3;
    g = (grp == 0) ? 16 : (grp == 1) ? 32 : 128;
    shv = (grp == 0) ? 4 : (grp == 1) ? 5 : 7;
    for (int s = 0; s < ns; s++) begin
      for (int b = 0; b < 128; b += g) begin
        sum = 0;
        for (int c = b; c < b + g; c++) sum += raw[s][c] - ped[c];
        a = sum >>> shv;
        for (int c = b; c < b + g; c++) c1[s][c] = sat(raw[s][c] - ped[c] - a);
        sum = 0;
        for (int c = b; c < b + g; c++) sum += (c1[s][c] > thr[c]) ? 0 : c1[s][c];
        a = sum >>> shv;
        for (int c = b; c < b + g; c++) c2[s][c] = sat(c1[s][c] - a);
      end
    end
    exp_n = 0;
    for (int c = 0; c < 128; c++) begin
      bit h = 0;
      logic [71:0] w = '0;
      for (int s = 0; s < ns; s++) begin
        t = byp ? raw[s][c] : c2[s][c];
        w[s*12 +: 12] = t[11:0];
        if (c2[s][c] > thr[c]) h = 1;
      end
      if (byp || h) begin exp_ch[exp_n] = c; exp_w[exp_n] = w; exp_n++; end
    end
  endtask

  task automatic write_tables();
    for (int c = 0; c < 128; c++) begin
      logic [31:0] t = thr[c];
      @(negedge clk); cfg_we = 1; cfg_sel = 0; cfg_addr = 7'(c); cfg_wdata = 12'(ped[c]);
      @(negedge clk); cfg_sel = 1; cfg_wdata = t[11:0];
    end
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic fill(input int lo, input int hi, input int noise);
    for (int c = 0; c < 128; c++) ped[c] = lo + ((c * 37) % (hi - lo + 1));
    for (int s = 0; s < 6; s++)
      for (int c = 0; c < 128; c++)
        raw[s][c] = ped[c] + 20 * (s + 1) + ((c / 16) % 3) * 5 + int'($urandom_range(0, noise));
  endtask

  task automatic run(input bit six, input bit byp, input int grp, input bit rnd, input string req);
    int ns, got, guard;
    bit held;
    logic [6:0] hch;
    logic [71:0] hw;
    model(six, byp, grp);
    ns = six ? 6 : 3;
    cfg_bypass = byp; cfg_grp = 2'(grp);
    for (int s = 0; s < ns; s++)
      for (int c = 0; c < 128; c++) begin
        @(negedge clk);
        in_valid = 1; in_first = (s == 0 && c == 0); in_six = six;
        in_chan = 7'(c); in_data = 10'(raw[s][c]);
      end
    @(negedge clk); in_valid = 0; in_first = 0;
    chk(in_ready == 0, "R2", "ready after last beat", in_ready, 0);
    got = 0; held = 0; guard = 0;
    while (!(in_ready && !out_valid) && guard < 20000) begin
      if (out_valid) begin
        if (held) chk(out_chan == hch && out_samples == hw, "R11", "held word", out_samples, hw);
        out_ready = rnd ? ($urandom_range(0, 2) != 0) : 1'b1;
        if (out_ready) begin
          if (got < exp_n) begin
            chk(out_chan == 7'(exp_ch[got]), req, "out_chan", out_chan, exp_ch[got]);
            chk(out_samples == exp_w[got], req, "out_samples", out_samples, exp_w[got]);
            chk(out_six == six, "R3", "out_six", out_six, six);
          end
          got++; held = 0;
        end else begin held = 1; hch = out_chan; hw = out_samples; end
      end else out_ready = 0;
      @(negedge clk); guard++;
    end
    out_ready = 0;
    chk(got == exp_n, req, "word count", got, exp_n);
  endtask

  task automatic t_reset();
    chk(out_valid == 0, "R1", "out_valid at reset", out_valid, 0);
    chk(in_ready == 1, "R1", "in_ready at reset", in_ready, 1);
  endtask

  task automatic t_quiet();
    fill(100, 300, 3);
    for (int c = 0; c < 128; c++) thr[c] = 40;
    write_tables();
    run(1, 0, 0, 0, "R4 R5 quiet");
  endtask

  task automatic t_hits_g16();
    fill(50, 400, 4);
    for (int c = 0; c < 128; c++) thr[c] = 25 + (c % 5) * 3;
    raw[2][7] += 90; raw[3][7] += 140; raw[4][40] += 60; raw[0][127] += 200;
    write_tables();
    run(1, 0, 0, 0, "R6 R8 R9 g16");
  endtask

  task automatic t_three_g32();
    fill(0, 200, 6);
    for (int c = 0; c < 128; c++) thr[c] = 30;
    raw[1][33] += 300; raw[0][64] += 80; raw[2][95] += 120;
    write_tables();
    run(0, 0, 1, 0, "R3 R6 g32");
  endtask

  task automatic t_g128_cluster();
    fill(200, 500, 2);
    for (int c = 0; c < 128; c++) thr[c] = 50;
    for (int c = 10; c < 30; c++) for (int s = 0; s < 6; s++) raw[s][c] += 250;
    write_tables();
    run(1, 0, 2, 0, "R7 g128");
  endtask

  task automatic t_bypass();
    fill(10, 900, 50);
    write_tables();
    run(0, 1, 0, 0, "R10 bypass");
  endtask

  task automatic t_backpressure();
    fill(0, 300, 3);
    for (int c = 0; c < 128; c++) thr[c] = (c % 2) ? 10 : 20;
    for (int c = 0; c < 128; c += 9) raw[c % 6][c] += 150;
    write_tables();
    run(1, 0, 0, 1, "R11 R8 stall");
  endtask

  task automatic t_ignore();
    fill(100, 300, 3);
    for (int c = 0; c < 128; c++) thr[c] = 30;
    raw[1][3] += 100;
    write_tables();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); in_valid = 1; in_first = 0; in_chan = 7'(k); in_data = 10'd1000;
    end
    @(negedge clk); in_valid = 0;
    chk(in_ready == 1, "R2", "idle after stray beats", in_ready, 1);
    run(1, 0, 0, 0, "R2 stray");
  endtask

  task automatic t_rewrite();
    for (int c = 0; c < 128; c++) thr[c] = 2047;
    write_tables();
    run(1, 0, 0, 0, "R12 thr max");
    for (int c = 0; c < 128; c++) thr[c] = -2048;
    write_tables();
    run(0, 0, 1, 0, "R12 thr min");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_quiet();
    t_hits_g16();
    t_three_g32();
    t_g128_cluster();
    t_bypass();
    t_backpressure();
    t_ignore();
    t_rewrite();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule